// File: doc/BRIEF.md
# Code Fetch Patch and Breakpoint Unit

This block sits beside the code-region request path and watches every instruction fetch and literal data load. Each request address is compared against a small bank of programmable comparators. When an enabled comparator hits, the unit either steers the access into a patch table in the system region, at an address fixed by the comparator's index, or hands the core a 16-bit breakpoint opcode in place of the fetched instruction. The original code-region access still goes out, because the comparison result arrives too late to cancel it. The unit therefore flags that original response for discard.

Software sets up the unit through a small register write/read port. It holds a global enable, a patch table base and one register per comparator. Comparators 0 to 5 watch instruction fetches only, and each can be set to remap or to a breakpoint mode. Comparators 6 and 7 watch literal loads only, and they always remap. A reduced build keeps only comparators 0 and 1, allows breakpoints only, and never remaps.

The request side takes a valid strobe, the byte address, the access kind, the size and an exclusive flag. Exactly one clock later the unit returns a response carrying the decision, the address to use, the breakpoint opcode word and the exclusive attribute for the outgoing access.

Top module: `fetch_patch_unit`

## Requirements
- R1: After reset, the global enable and all comparator registers are zero, every register reads back zero, and no request is remapped or replaced by a breakpoint.
- R2: For each cycle in which req_valid_i is high, rsp_valid_o is high exactly one cycle later. It is low in every other cycle.
- R3: A comparator hits only when the global enable (register 0, bit 0) and its own enable (bit 0) are both set, when req_addr_i[31:29] is 0, and when req_addr_i[28:2] equals its match field (bits [28:2]).
- R4: Comparators 0 to 5 hit only on fetches (req_lit_i=0). Comparators 6 and 7 hit only on literal loads (req_lit_i=1).
- R5: A remapped access goes to 0x2000_0000 plus the patch base (register 1, bits [28:5]), plus 4 times the winning comparator's index, plus req_addr_i[1:0].
- R6: Fetch comparators use a mode field in bits [31:30]. The value 0 means remap. The value 1 puts 0xBE00 in rsp_insn_o[15:0], the value 2 puts it in rsp_insn_o[31:16], and the value 3 puts it in both halves. In a breakpoint mode there is no remap, and the request address is passed through. Unused halves are zero.
- R7: When several comparators hit, the lowest index wins, and its action alone decides the response.
- R8: rsp_discard_o is high exactly when the response is a remap or a breakpoint. With no action, rsp_addr_o equals the request address and rsp_insn_o is zero.
- R9: A literal load that is misaligned for its size (size 1 = halfword with bit 0 set, size 2 = word with bits [1:0] non-zero) is never remapped, and the original access proceeds.
- R10: rsp_excl_o copies req_excl_i, except that it is cleared when the access is remapped.
- R11: In the reduced build, registers 4 to 9 read zero and ignore writes. A remap-mode hit produces no action, while breakpoint modes work as in R6.
- R12: The register map is: 0 holds the control bit (bit 0), 1 holds the base (bits [28:5]), and 2+n holds comparator n. Bits outside these fields read back zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register index for write and read |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | 32 | Request byte address |
| req_lit_i | input | 1 | 1 = literal load, 0 = instruction fetch |
| req_size_i | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| req_excl_i | input | 1 | Exclusive load flag |
| rsp_valid_o | output | 1 | Response valid |
| rsp_remap_o | output | 1 | Access remapped to the patch table |
| rsp_bkpt_o | output | 1 | Breakpoint substituted |
| rsp_discard_o | output | 1 | Discard the original code-region response |
| rsp_excl_o | output | 1 | Exclusive attribute for the outgoing access |
| rsp_addr_o | output | 32 | Address to use for the access |
| rsp_insn_o | output | 32 | Breakpoint opcode word |

## Verification
A corrupted comparator register or enable shows up on the first matching request. The corruption is visible one cycle later as a missing or spurious remap or breakpoint flag, or as a wrong patch-table slot in rsp_addr_o. A wrong priority or a wrong kind of comparator shows only when overlapping or cross-kind comparators are programmed, so the bench sets up such overlaps on purpose. Readback on the register port exposes stored field corruption at once, without any request.

// File: rtl/fpu_pkg.sv
package fpu_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned N_INSN = 6;
  localparam int unsigned N_MAX  = 8;
  localparam int unsigned IDX_W  = $clog2(N_MAX);
  localparam int unsigned REG_AW = 4;
  localparam logic [15:0] BKPT_OP = 16'hBE00;
  localparam logic [2:0]  SYS_TOP = 3'b001;

  typedef enum logic [1:0] {
    ACT_REMAP   = 2'd0,
    ACT_BK_LO   = 2'd1,
    ACT_BK_HI   = 2'd2,
    ACT_BK_BOTH = 2'd3
  } cmp_mode_e;

  typedef struct packed {
    cmp_mode_e   mode;
    logic [28:2] match;
    logic        en;
  } cmp_cfg_t;
endpackage

// File: rtl/fpu_cfg_regs.sv
module fpu_cfg_regs
  import fpu_pkg::*;
#(
  parameter int unsigned N_CMP = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              glob_en_o,
  output logic [28:5]       base_o,
  output cmp_cfg_t          cmp_o [N_CMP]
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[29], wdata_i[4:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_en_o <= 1'b0;
      base_o    <= '0;
    end else if (we_i) begin
      if (addr_i == REG_AW'(0)) glob_en_o <= wdata_i[0];
      if (addr_i == REG_AW'(1)) base_o    <= wdata_i[28:5];
    end
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_slot
    localparam logic [REG_AW-1:0] SLOT = REG_AW'(2 + i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_o[i] <= '{mode: ACT_REMAP, match: '0, en: 1'b0};
      end else if (we_i && addr_i == SLOT) begin
        cmp_o[i] <= '{mode: cmp_mode_e'(wdata_i[31:30]), match: wdata_i[28:2], en: wdata_i[0]};
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == REG_AW'(0)) rdata_o = {31'b0, glob_en_o};
    if (addr_i == REG_AW'(1)) rdata_o = {3'b0, base_o, 5'b0};
    for (int i = 0; i < int'(N_CMP); i++) begin
      if (addr_i == REG_AW'(2 + i))
        rdata_o = {cmp_o[i].mode, 1'b0, cmp_o[i].match, 1'b0, cmp_o[i].en};
    end
  end

  assert_ctrl_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_AW'(0)) |=> glob_en_o == $past(wdata_i[0]));

  assert_base_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_AW'(1)) |=> base_o == $past(wdata_i[28:5]));
endmodule

// File: rtl/fpu_cmp_bank.sv
module fpu_cmp_bank
  import fpu_pkg::*;
#(
  parameter int unsigned N_CMP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glob_en_i,
  input  cmp_cfg_t         cmp_i [N_CMP],
  input  logic [31:2]      addr_i,
  input  logic             lit_i,
  output logic             any_hit_o,
  output logic [IDX_W-1:0] win_idx_o,
  output cmp_mode_e        win_mode_o
);
  logic [N_CMP-1:0] hit;
  logic             in_code;

  assign in_code = (addr_i[31:29] == 3'b000);

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    localparam bit IS_LIT = (i >= N_INSN);
    assign hit[i] = glob_en_i && cmp_i[i].en && in_code &&
                    (lit_i == IS_LIT) && (cmp_i[i].match == addr_i[28:2]);
  end

  // lowest index wins
  always_comb begin
    win_idx_o  = '0;
    win_mode_o = ACT_REMAP;
    for (int i = int'(N_CMP) - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_idx_o  = IDX_W'(i);
        win_mode_o = cmp_i[i].mode;
      end
    end
  end

  assign any_hit_o = |hit;

  assert_hit_needs_global_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit_o |-> glob_en_i && addr_i[31:29] == 3'b000);

  assert_kind_split_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit_o |-> (lit_i == (32'(win_idx_o) >= N_INSN)));
endmodule

// File: rtl/fpu_resp.sv
module fpu_resp
  import fpu_pkg::*;
#(
  parameter bit FULL_BUILD = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [31:0]      req_addr_i,
  input  logic             req_lit_i,
  input  logic [1:0]       req_size_i,
  input  logic             req_excl_i,
  input  logic             any_hit_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  cmp_mode_e        win_mode_i,
  input  logic [28:5]      base_i,
  output logic             rsp_valid_o,
  output logic             rsp_remap_o,
  output logic             rsp_bkpt_o,
  output logic             rsp_discard_o,
  output logic             rsp_excl_o,
  output logic [31:0]      rsp_addr_o,
  output logic [31:0]      rsp_insn_o
);
  logic        misaligned, win_lit, do_remap, do_bkpt;
  logic [31:0] remap_addr, bk_word;

  always_comb begin
    unique case (req_size_i)
      2'd1:    misaligned = req_addr_i[0];
      2'd2:    misaligned = |req_addr_i[1:0];
      default: misaligned = 1'b0;
    endcase
  end

  assign win_lit  = (32'(win_idx_i) >= N_INSN);
  assign do_bkpt  = any_hit_i && !win_lit && (win_mode_i != ACT_REMAP);
  assign do_remap = FULL_BUILD && any_hit_i &&
                    (win_lit ? !misaligned : (win_mode_i == ACT_REMAP));
  // base is 32-byte aligned: slot offset concatenates without an adder
  assign remap_addr = {SYS_TOP, base_i, win_idx_i, req_addr_i[1:0]};

  always_comb begin
    bk_word = '0;
    if (do_bkpt) begin
      if (win_mode_i == ACT_BK_LO || win_mode_i == ACT_BK_BOTH) bk_word[15:0]  = BKPT_OP;
      if (win_mode_i == ACT_BK_HI || win_mode_i == ACT_BK_BOTH) bk_word[31:16] = BKPT_OP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_remap_o   <= 1'b0;
      rsp_bkpt_o    <= 1'b0;
      rsp_discard_o <= 1'b0;
      rsp_excl_o    <= 1'b0;
      rsp_addr_o    <= '0;
      rsp_insn_o    <= '0;
    end else begin
      rsp_valid_o   <= req_valid_i;
      rsp_remap_o   <= req_valid_i && do_remap;
      rsp_bkpt_o    <= req_valid_i && do_bkpt;
      rsp_discard_o <= req_valid_i && (do_remap || do_bkpt);
      rsp_excl_o    <= req_valid_i && req_excl_i && !do_remap;
      rsp_addr_o    <= do_remap ? remap_addr : req_addr_i;
      rsp_insn_o    <= req_valid_i ? bk_word : '0;
    end
  end

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_single_action_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_remap_o && rsp_bkpt_o));

  assert_passthru_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_remap_o) |-> rsp_addr_o == $past(req_addr_i));

  assert_no_misaligned_lit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_lit_i && req_size_i == 2'd2 && req_addr_i[1:0] != 2'b00)
    |=> !rsp_remap_o);

  assert_excl_dropped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_remap_o |-> !rsp_excl_o);

  assert_remap_in_sys_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_remap_o |-> rsp_addr_o[31:29] == SYS_TOP);

  assert_min_no_remap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !FULL_BUILD |-> !rsp_remap_o);
endmodule

// File: rtl/fetch_patch_unit.sv
module fetch_patch_unit
  import fpu_pkg::*;
#(
  parameter bit FULL_BUILD = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [3:0]  cfg_addr_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        req_valid_i,
  input  logic [31:0] req_addr_i,
  input  logic        req_lit_i,
  input  logic [1:0]  req_size_i,
  input  logic        req_excl_i,
  output logic        rsp_valid_o,
  output logic        rsp_remap_o,
  output logic        rsp_bkpt_o,
  output logic        rsp_discard_o,
  output logic        rsp_excl_o,
  output logic [31:0] rsp_addr_o,
  output logic [31:0] rsp_insn_o
);
  localparam int unsigned N_CMP = FULL_BUILD ? N_MAX : 2;

  logic             glob_en;
  logic [28:5]      base;
  cmp_cfg_t         cmp_cfg [N_CMP];
  logic             any_hit;
  logic [IDX_W-1:0] win_idx;
  cmp_mode_e        win_mode;

  fpu_cfg_regs #(.N_CMP(N_CMP)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .glob_en_o(glob_en),
    .base_o   (base),
    .cmp_o    (cmp_cfg)
  );

  fpu_cmp_bank #(.N_CMP(N_CMP)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .glob_en_i (glob_en),
    .cmp_i     (cmp_cfg),
    .addr_i    (req_addr_i[31:2]),
    .lit_i     (req_lit_i),
    .any_hit_o (any_hit),
    .win_idx_o (win_idx),
    .win_mode_o(win_mode)
  );

  fpu_resp #(.FULL_BUILD(FULL_BUILD)) u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_addr_i   (req_addr_i),
    .req_lit_i    (req_lit_i),
    .req_size_i   (req_size_i),
    .req_excl_i   (req_excl_i),
    .any_hit_i    (any_hit),
    .win_idx_i    (win_idx),
    .win_mode_i   (win_mode),
    .base_i       (base),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_remap_o  (rsp_remap_o),
    .rsp_bkpt_o   (rsp_bkpt_o),
    .rsp_discard_o(rsp_discard_o),
    .rsp_excl_o   (rsp_excl_o),
    .rsp_addr_o   (rsp_addr_o),
    .rsp_insn_o   (rsp_insn_o)
  );

  assert_disabled_no_action_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !glob_en) |=> !rsp_discard_o);
endmodule

// File: tb/fetch_patch_unit_tb.sv
module fetch_patch_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        we0 = 0, we1 = 0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        req_valid = 0, req_lit = 0, req_excl = 0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic        v0, rm0, bk0, dc0, ex0, v1, rm1, bk1, dc1, ex1;
  logic [31:0] a0, i0, a1, i1;

  fetch_patch_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we0), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(rdata0), .req_valid_i(req_valid),
    .req_addr_i(req_addr), .req_lit_i(req_lit), .req_size_i(req_size),
    .req_excl_i(req_excl), .rsp_valid_o(v0), .rsp_remap_o(rm0), .rsp_bkpt_o(bk0),
    .rsp_discard_o(dc0), .rsp_excl_o(ex0), .rsp_addr_o(a0), .rsp_insn_o(i0));

  fetch_patch_unit #(.FULL_BUILD(1'b0)) u_dut_min (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we1), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(rdata1), .req_valid_i(req_valid),
    .req_addr_i(req_addr), .req_lit_i(req_lit), .req_size_i(req_size),
    .req_excl_i(req_excl), .rsp_valid_o(v1), .rsp_remap_o(rm1), .rsp_bkpt_o(bk1),
    .rsp_discard_o(dc1), .rsp_excl_o(ex1), .rsp_addr_o(a1), .rsp_insn_o(i1));

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  typedef struct packed {
    logic        remap, bkpt, discard, excl;
    logic [31:0] addr, insn;
  } exp_t;

  exp_t  q0[$], q1[$];
  string t0[$], t1[$];

  logic [31:0] sh_ctrl [2];
  logic [31:0] sh_base [2];
  logic [31:0] sh_cmp  [2][8];

  function automatic exp_t model(int d, logic [31:0] ad, logic lit, logic [1:0] sz, logic ex);
    exp_t e;
    int n_cmp = (d == 0) ? 8 : 2;
    int win = -1;
    logic mis;
    logic [1:0] md;
    e = '0;
    e.addr = ad;
    mis = (sz == 2'd1) ? ad[0] : (sz == 2'd2) ? (ad[1:0] != 2'b00) : 1'b0;
    for (int i = n_cmp - 1; i >= 0; i--) begin
      if (sh_ctrl[d][0] && sh_cmp[d][i][0] && ad[31:29] == 3'b000 &&
          (lit == (i >= 6)) && sh_cmp[d][i][28:2] == ad[28:2]) win = i;
    end
    if (win >= 0) begin
      md = sh_cmp[d][win][31:30];
      if (win < 6 && md != 2'd0) begin
        e.bkpt = 1;
        if (md[0]) e.insn[15:0]  = 16'hBE00;
        if (md[1]) e.insn[31:16] = 16'hBE00;
      end else if (d == 0 && (win < 6 || !mis)) begin
        e.remap = 1;
        e.addr = 32'h2000_0000 | (sh_base[d] & 32'h1FFF_FFE0) | (32'(win) << 2) | {30'b0, ad[1:0]};
      end
    end
    e.discard = e.remap | e.bkpt;
    e.excl = ex & ~e.remap;
    return e;
  endfunction

  task automatic cfg_wr(int d, logic [3:0] ad, logic [31:0] wd);
    @(negedge clk);
    cfg_addr = ad; cfg_wdata = wd;
    if (d == 0) we0 = 1; else we1 = 1;
    @(negedge clk);
    we0 = 0; we1 = 0;
    if (ad == 0) sh_ctrl[d] = {31'b0, wd[0]};
    else if (ad == 1) sh_base[d] = wd & 32'h1FFF_FFE0;
    else if (ad >= 2 && int'(ad) < ((d == 0) ? 10 : 4)) sh_cmp[d][ad - 2] = wd & 32'hDFFF_FFFD;
  endtask

  task automatic rd_chk(int d, logic [3:0] ad, logic [31:0] exp, string tag);
    logic [31:0] got;
    @(negedge clk);
    cfg_addr = ad;
    #1;
    got = (d == 0) ? rdata0 : rdata1;
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: dut%0d reg %0d read %h expected %h", tag, d, ad, got, exp);
    end
  endtask

  task automatic send(logic [31:0] ad, logic lit, logic [1:0] sz, logic ex);
    @(negedge clk);
    req_valid = 1; req_addr = ad; req_lit = lit; req_size = sz; req_excl = ex;
    q0.push_back(model(0, ad, lit, sz, ex)); t0.push_back(cur_tag);
    q1.push_back(model(1, ad, lit, sz, ex)); t1.push_back(cur_tag);
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  function automatic void cmp_rsp(int d, exp_t e, string tag, exp_t g);
    n_vec++;
    if (g !== e) begin
      n_bad++;
      $display("FAIL %s: dut%0d rsp {rm,bk,dc,ex}=%b addr=%h insn=%h expected %b addr=%h insn=%h",
               tag, d, {g.remap, g.bkpt, g.discard, g.excl}, g.addr, g.insn,
               {e.remap, e.bkpt, e.discard, e.excl}, e.addr, e.insn);
    end
  endfunction

  // monitor: responses sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (v0) begin
        if (q0.size() == 0) begin
          n_vec++; n_bad++;
          $display("FAIL R2: dut0 unexpected response valid=1 expected 0");
        end else cmp_rsp(0, q0.pop_front(), t0.pop_front(), '{rm0, bk0, dc0, ex0, a0, i0});
      end
      if (v1) begin
        if (q1.size() == 0) begin
          n_vec++; n_bad++;
          $display("FAIL R2: dut1 unexpected response valid=1 expected 0");
        end else cmp_rsp(1, q1.pop_front(), t1.pop_front(), '{rm1, bk1, dc1, ex1, a1, i1});
      end
    end
  end

  task automatic finish_run();
    if (q0.size() != 0 || q1.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R2: %0d responses missing expected 0", q0.size() + q1.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      sh_ctrl[d] = '0; sh_base[d] = '0;
      for (int i = 0; i < 8; i++) sh_cmp[d][i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int r = 0; r < 10; r++) rd_chk(0, 4'(r), 32'h0, "R1");
    cur_tag = "R1";
    send(32'h0000_0000, 0, 2'd2, 0);
    drain();

    // R12: field masks on readback
    cfg_wr(0, 4'd1, 32'hFFFF_FFFF);
    rd_chk(0, 4'd1, 32'h1FFF_FFE0, "R12");
    cfg_wr(0, 4'd9, 32'hFFFF_FFFF);
    rd_chk(0, 4'd9, 32'hDFFF_FFFD, "R12");
    cfg_wr(0, 4'd9, 32'h0);
    cfg_wr(0, 4'd0, 32'hFFFF_FFFF);
    rd_chk(0, 4'd0, 32'h1, "R12");

    // program full build
    cfg_wr(0, 4'd1, 32'h0000_1000);
    cfg_wr(0, 4'd2, 32'h0000_0101);            // cmp0 remap 0x100
    cfg_wr(0, 4'd5, 32'h4000_0201);            // cmp3 bkpt lo 0x200
    cfg_wr(0, 4'd6, 32'h8000_0205);            // cmp4 bkpt hi 0x204
    cfg_wr(0, 4'd7, 32'hC000_0209);            // cmp5 bkpt both 0x208
    cfg_wr(0, 4'd8, 32'h0000_0301);            // cmp6 literal 0x300
    cfg_wr(0, 4'd9, 32'hC000_0401);            // cmp7 literal 0x400, mode ignored
    cfg_wr(0, 4'd3, 32'h0000_0501);            // cmp1 remap 0x500
    cfg_wr(0, 4'd4, 32'h4000_0501);            // cmp2 bkpt 0x500
    rd_chk(0, 4'd5, 32'h4000_0201, "R12");

    cur_tag = "R5";  send(32'h0000_0100, 0, 2'd2, 0);
    cur_tag = "R5";  send(32'h0000_0102, 0, 2'd1, 0);
    cur_tag = "R6";  send(32'h0000_0200, 0, 2'd1, 0);
    cur_tag = "R6";  send(32'h0000_0206, 0, 2'd1, 0);
    cur_tag = "R6";  send(32'h0000_0208, 0, 2'd2, 0);
    cur_tag = "R4";  send(32'h0000_0300, 1, 2'd2, 0);
    cur_tag = "R4";  send(32'h0000_0300, 0, 2'd2, 0);
    cur_tag = "R4";  send(32'h0000_0100, 1, 2'd2, 0);
    cur_tag = "R9";  send(32'h0000_0301, 1, 2'd2, 0);
    cur_tag = "R9";  send(32'h0000_0302, 1, 2'd1, 0);
    cur_tag = "R9";  send(32'h0000_0303, 1, 2'd0, 0);
    cur_tag = "R10"; send(32'h0000_0400, 1, 2'd2, 1);
    cur_tag = "R10"; send(32'h0000_0600, 1, 2'd2, 1);
    cur_tag = "R7";  send(32'h0000_0500, 0, 2'd2, 0);
    cur_tag = "R3";  send(32'h2000_0100, 0, 2'd2, 0);
    cur_tag = "R8";  send(32'h0000_0104, 0, 2'd2, 1);
    drain();

    // R7: disable cmp1 -> cmp2 breakpoint wins
    cfg_wr(0, 4'd3, 32'h0000_0500);
    cur_tag = "R7"; send(32'h0000_0500, 0, 2'd2, 0);
    drain();

    // R3: global disable
    cfg_wr(0, 4'd0, 32'h0);
    cur_tag = "R3"; send(32'h0000_0100, 0, 2'd2, 0);
    cur_tag = "R3"; send(32'h0000_0200, 0, 2'd2, 0);
    drain();

    // R11: reduced build
    cfg_wr(1, 4'd0, 32'h1);
    cfg_wr(1, 4'd1, 32'h0000_1000);
    cfg_wr(1, 4'd2, 32'h0000_0101);            // remap mode: no action
    cfg_wr(1, 4'd3, 32'h8000_0105);            // bkpt hi 0x104
    cfg_wr(1, 4'd4, 32'h0000_0301);            // absent slot
    rd_chk(1, 4'd4, 32'h0, "R11");
    rd_chk(1, 4'd9, 32'h0, "R11");
    rd_chk(1, 4'd3, 32'h8000_0105, "R11");
    cur_tag = "R11"; send(32'h0000_0100, 0, 2'd2, 1);
    cur_tag = "R11"; send(32'h0000_0104, 0, 2'd2, 0);
    cur_tag = "R11"; send(32'h0000_0300, 1, 2'd2, 0);
    drain();

    // R2: back-to-back then a gap
    cfg_wr(0, 4'd0, 32'h1);
    cur_tag = "R2";
    for (int k = 0; k < 6; k++) send(32'h0000_0100 + 32'(k * 4), 0, 2'd2, k[0]);
    drain();

    finish_run();
  end
endmodule